// File: doc/BRIEF.md
# Vector Saturating Narrowing Shifter

This block narrows a 256-bit vector of wide integer elements into half-width elements in a single step. Each wide element of operand A is shifted right by its own amount, taken from the element of operand B at the same position. The shifted value is then clamped to the range of the narrow result type. The shift can be logical (zero fill) or arithmetic (sign fill). The clamp can target a signed or an unsigned narrow range. Source element widths of 16, 32 and 64 bits are supported.

The vector is split into two independent 128-bit halves. In each half, the narrowed results are packed in lane order into the low 64 bits, and the upper 64 bits are cleared. The datapath is combinational and feeds one output register. A two-state controller tracks whether the register holds a fresh result.

The controller has two states:
- `ST_IDLE`: no new result is being presented.
- `ST_LIVE`: the output register was loaded on the previous edge.

It has three transitions:
- `T_ACCEPT` (ST_IDLE to ST_LIVE) on `valid_in`.
- `T_CHAIN` (ST_LIVE to ST_LIVE) on `valid_in`.
- `T_DRAIN` (ST_LIVE to ST_IDLE) when `valid_in` is low.

Top module: `vnarrow_sat_shift`

## Requirements
- R1: In each 128-bit half h, the narrowed result of source lane i is written to bits [h*128 + i*W +: W], where W is half the source width. Lanes keep their order.
- R2: Bits 127:64 and 255:192 of `result` are always zero.
- R3: Each lane's shift amount is the full source-width element of `src_b` at the same position, taken modulo the source width. An amount of zero, or any multiple of the source width, passes the element unshifted to the clamp stage.
- R4: With op[2]=0 and op[3]=0 (logical, signed range), the source is unsigned and zeros are shifted in. Any value above 2^(W-1)-1 becomes 2^(W-1)-1.
- R5: With op[2]=0 and op[3]=1 (logical, unsigned range), the source is unsigned. Any value above 2^W-1 becomes 2^W-1.
- R6: With op[2]=1 and op[3]=0 (arithmetic, signed range), the source is two's complement and sign bits are shifted in. The result is clamped to the range -2^(W-1) to 2^(W-1)-1.
- R7: With op[2]=1 and op[3]=1 (arithmetic, unsigned range), a negative source element gives 0. Otherwise the shifted value is clamped to 2^W-1.
- R8: op[1:0] selects the source width: 0 selects 16 to 8, 1 selects 32 to 16, and 2 selects 64 to 32. Code 3 makes the whole captured result zero.
- R9: `valid_out` is high exactly in the cycle after a cycle with `valid_in` high. `result` loads only when `valid_in` is high, and holds otherwise.
- R10: A synchronous active-high `rst` clears `result` and `valid_out` on the next edge. It takes priority over `valid_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Operands and op are valid this cycle |
| op | input | 4 | {unsigned range, arithmetic, size[1:0]} |
| src_a | input | 256 | Wide elements to narrow |
| src_b | input | 256 | Per-lane shift amounts |
| valid_out | output | 1 | `result` was captured on the last edge |
| result | output | 256 | Registered narrowed vector |

## Verification
Reset and capture can fall in the same cycle. The bench raises `rst` together with `valid_in` and a nonzero operand set, then checks that the register comes out cleared and `valid_out` low. Shifting and clamping also act together in every lane. Sweeps over all sixteen op codes with sign-heavy, small and random operands make the shifted value land inside the narrow range, above it and below it. Each result is compared against an arithmetic model written with ordinary integer comparisons.

// File: rtl/vns_pkg.sv
package vns_pkg;

    // Smallest supported source element width and number of width options.
    localparam int MIN_SRC_W = 16;
    localparam int NUM_SIZES = 3;

    typedef enum logic [1:0] {
        SZ_H2B  = 2'd0,   // 16 -> 8
        SZ_W2H  = 2'd1,   // 32 -> 16
        SZ_D2W  = 2'd2,   // 64 -> 32
        SZ_NONE = 2'd3    // unused: result zero
    } size_e;

    typedef struct packed {
        logic  usat;      // op[3]: clamp to unsigned range
        logic  arith;     // op[2]: sign-filling shift
        size_e size;      // op[1:0]
    } op_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LIVE = 1'b1
    } state_e;

endpackage

// File: rtl/vns_lane.sv
module vns_lane #(
    parameter int SRC_W = 16
) (
    input  logic [SRC_W-1:0]   src,
    input  logic [SRC_W-1:0]   amt,
    input  logic               arith,
    input  logic               usat,
    output logic [SRC_W/2-1:0] dst
);
    localparam int DST_W = SRC_W / 2;
    localparam logic [SRC_W-1:0] MODULUS = SRC_W;
    localparam logic [DST_W-1:0] SMAX = {1'b0, {(DST_W-1){1'b1}}};
    localparam logic [DST_W-1:0] SMIN = {1'b1, {(DST_W-1){1'b0}}};

    logic [SRC_W-1:0]        amt_mod;
    logic [SRC_W-1:0]        shr_log;
    logic signed [SRC_W-1:0] shr_ari;
    logic [SRC_W-1:0]        shifted;
    logic [DST_W:0]          upper_s;   // bits that must agree for a signed fit
    logic [DST_W-1:0]        upper_u;   // bits that must be zero for an unsigned fit
    logic                    src_neg;

    always_comb begin
        amt_mod = amt % MODULUS;
        shr_log = src >> amt_mod;
        shr_ari = $signed(src) >>> amt_mod;
        shifted = arith ? $unsigned(shr_ari) : shr_log;
        upper_s = shifted[SRC_W-1:DST_W-1];
        upper_u = shifted[SRC_W-1:DST_W];
        src_neg = arith & src[SRC_W-1];
    end

    always_comb begin
        dst = shifted[DST_W-1:0];
        if (!usat) begin
            if (arith) begin
                if (!((&upper_s) || !(|upper_s))) begin
                    dst = shifted[SRC_W-1] ? SMIN : SMAX;
                end
            end else if (|upper_s) begin
                dst = SMAX;
            end
        end else begin
            if (src_neg) begin
                dst = '0;
            end else if (|upper_u) begin
                dst = '1;
            end
        end
    end

endmodule

// File: rtl/vns_half.sv
module vns_half
    import vns_pkg::*;
#(
    parameter int HALF_W = 128
) (
    input  logic [HALF_W-1:0] a_half,
    input  logic [HALF_W-1:0] b_half,
    input  size_e             size,
    input  logic              arith,
    input  logic              usat,
    output logic [HALF_W-1:0] res_half
);
    localparam int PACK_W = HALF_W / 2;

    logic [NUM_SIZES-1:0][PACK_W-1:0] by_size;

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int SW    = MIN_SRC_W << k;
        localparam int DW    = SW / 2;
        localparam int LANES = HALF_W / SW;
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            vns_lane #(.SRC_W(SW)) u_lane (
                .src   (a_half[i*SW +: SW]),
                .amt   (b_half[i*SW +: SW]),
                .arith (arith),
                .usat  (usat),
                .dst   (by_size[k][i*DW +: DW])
            );
        end
    end

    always_comb begin
        res_half = '0;
        unique case (size)
            SZ_H2B:  res_half[PACK_W-1:0] = by_size[0];
            SZ_W2H:  res_half[PACK_W-1:0] = by_size[1];
            SZ_D2W:  res_half[PACK_W-1:0] = by_size[2];
            SZ_NONE: res_half = '0;
        endcase
    end

endmodule

// File: rtl/vnarrow_sat_shift.sv
module vnarrow_sat_shift
    import vns_pkg::*;
#(
    parameter int VEC_W  = 256,
    parameter int HALF_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_in,
    input  logic [3:0]       op,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    output logic             valid_out,
    output logic [VEC_W-1:0] result
);
    localparam int NUM_HALVES = VEC_W / HALF_W;

    op_t              opc;
    logic [VEC_W-1:0] next_result;
    state_e           state_q;
    state_e           state_d;

    assign opc = op_t'(op);

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        vns_half #(.HALF_W(HALF_W)) u_half (
            .a_half   (src_a[h*HALF_W +: HALF_W]),
            .b_half   (src_b[h*HALF_W +: HALF_W]),
            .size     (opc.size),
            .arith    (opc.arith),
            .usat     (opc.usat),
            .res_half (next_result[h*HALF_W +: HALF_W])
        );
    end

    // Transitions: T_ACCEPT, T_CHAIN, T_DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (valid_in)  state_d = ST_LIVE;   // T_ACCEPT
            ST_LIVE: if (!valid_in) state_d = ST_IDLE;   // T_DRAIN (else T_CHAIN)
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else if (valid_in) begin
            result <= next_result;
        end
    end

    assign valid_out = (state_q == ST_LIVE);

endmodule

// File: rtl/vns_checker.sv
module vns_checker #(
    parameter int VEC_W  = 256,
    parameter int HALF_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             valid_in,
    input logic [1:0]       size_in,
    input logic             valid_out,
    input logic [VEC_W-1:0] result
);
    localparam int NUM_HALVES = VEC_W / HALF_W;
    localparam int PACK_W     = HALF_W / 2;

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!valid_out && result == '0)); // R10
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) valid_in |=> valid_out); // R9
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !valid_in |=> !valid_out); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !valid_in |=> $stable(result)); // R9
    AST_UNUSED_SIZE: assert property (@(posedge clk) disable iff (rst) (valid_in && size_in == 2'b11) |=> result == '0); // R8

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_hz
        AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst) result[h*HALF_W+PACK_W +: PACK_W] == '0); // R2
    end

endmodule

bind vnarrow_sat_shift vns_checker #(.VEC_W(VEC_W), .HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (valid_in),
    .size_in   (op[1:0]),
    .valid_out (valid_out),
    .result    (result)
);

// File: tb/vnarrow_sat_shift_test.sv
`timescale 1ns/1ps
module vnarrow_sat_shift_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_in = 1'b0;
    logic [3:0]   op = 4'd0;
    logic [255:0] src_a = '0;
    logic [255:0] src_b = '0;
    logic         valid_out;
    logic [255:0] result;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    vnarrow_sat_shift uut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .op(op),
        .src_a(src_a), .src_b(src_b), .valid_out(valid_out), .result(result)
    );

    task automatic check_vec(string req, logic [255:0] got, logic [255:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s op=%h got=%h exp=%h", req, op, got, exp);
        end
    endtask

    task automatic check_bit(string req, logic got, logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b", req, got, exp);
        end
    endtask

    // Arithmetic model of one lane: sw = source width, returns w = sw/2 bits.
    function automatic logic [31:0] model_lane(logic [63:0] e, logic [63:0] eb, int sw,
                                               bit ari, bit uns);
        int          w    = sw / 2;
        int          sh   = int'(eb % 64'(sw));
        longint      maxs = (64'sd1 <<< (w - 1)) - 1;
        longint      mins = -(64'sd1 <<< (w - 1));
        longint      maxu = (64'sd1 <<< w) - 1;
        longint      sx;
        longint      x;
        logic [63:0] u;
        longint      r;
        sx = $signed(e << (64 - sw)) >>> (64 - sw);
        if (!ari) begin
            u = e >> sh;
            if (!uns) r = (u > 64'(maxs)) ? maxs : longint'(u);
            else      r = (u > 64'(maxu)) ? maxu : longint'(u);
        end else begin
            x = sx >>> sh;
            if (!uns) r = (x > maxs) ? maxs : ((x < mins) ? mins : x);
            else      r = (sx < 0) ? 0 : ((x > maxu) ? maxu : x);
        end
        return 32'(r & maxu);
    endfunction

    function automatic logic [255:0] model_vec(logic [3:0] o, logic [255:0] a, logic [255:0] b);
        logic [255:0] res = '0;
        int sw;
        logic [63:0] msk;
        if (o[1:0] == 2'd3) return '0;
        sw  = 16 << o[1:0];
        msk = (sw == 64) ? '1 : ((64'd1 << sw) - 1);
        for (int h = 0; h < 2; h++) begin
            for (int i = 0; i < 128 / sw; i++) begin
                logic [63:0] ea = 64'(a >> (h*128 + i*sw)) & msk;
                logic [63:0] eb = 64'(b >> (h*128 + i*sw)) & msk;
                logic [31:0] r  = model_lane(ea, eb, sw, o[2], o[3]);
                res |= (256'(r) << (h*128 + i*(sw/2)));
            end
        end
        return res;
    endfunction

    function automatic string tag_of(logic [3:0] o);
        if (o[1:0] == 2'd3) return "R8";
        case (o[3:2])
            2'b00:   return "R4";
            2'b10:   return "R5";
            2'b01:   return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    // Drive one operation for one cycle; returns at the negedge after capture.
    task automatic apply(logic [3:0] o, logic [255:0] a, logic [255:0] b);
        @(negedge clk);
        op = o; src_a = a; src_b = b; valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [255:0] a;
        logic [255:0] b;
        logic [255:0] held;
        void'($urandom(32'h5eed));

        // R10: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_vec("R10 reset result", result, '0);
        check_bit("R10 reset valid_out", valid_out, 1'b0);

        // R4..R7: 0x8000 in every 16-bit lane, no shift
        a = {16{16'h8000}};
        apply(4'b0000, a, '0);
        check_vec("R4 clamp to 0x7f", result, {64'h0, {8{8'h7f}}, 64'h0, {8{8'h7f}}});
        check_bit("R9 valid_out after valid_in", valid_out, 1'b1);
        apply(4'b1000, a, '0);
        check_vec("R5 clamp to 0xff", result, {64'h0, {8{8'hff}}, 64'h0, {8{8'hff}}});
        apply(4'b0100, a, '0);
        check_vec("R6 clamp to 0x80", result, {64'h0, {8{8'h80}}, 64'h0, {8{8'h80}}});
        apply(4'b1100, a, '0);
        check_vec("R7 negative gives 0", result, '0);

        // R3: amount 16 wraps to 0; amount 20 acts as 4
        apply(4'b1000, {16{16'h0056}}, {16{16'h0010}});
        check_vec("R3 amount modulo width", result, {64'h0, {8{8'h56}}, 64'h0, {8{8'h56}}});
        apply(4'b1000, {16{16'h0560}}, {16{16'h0014}});
        check_vec("R3 amount 20 acts as 4", result, {64'h0, {8{8'h56}}, 64'h0, {8{8'h56}}});

        // R1: lane order and placement per half
        a = '0;
        for (int i = 0; i < 16; i++) a[i*16 +: 16] = 16'(i * 5 + 1);
        b = '0;
        apply(4'b0000, a, b);
        begin
            logic [255:0] e = '0;
            for (int h = 0; h < 2; h++)
                for (int i = 0; i < 8; i++) e[h*128 + i*8 +: 8] = 8'((h*8 + i) * 5 + 1);
            check_vec("R1 lane placement", result, e);
        end

        // R2 and R8: unused size code with nonzero operands
        apply(4'b0111, rnd256(), rnd256());
        check_vec("R8 unused size zero", result, '0);
        apply(4'b1010, {256{1'b1}}, '0);
        check_vec("R2 upper halves zero", result & {64'hffffffffffffffff, 64'h0, 64'hffffffffffffffff, 64'h0}, '0);

        // R9: hold when valid_in low
        held = result;
        @(negedge clk);
        src_a = rnd256(); op = 4'b0000;
        @(negedge clk);
        check_bit("R9 valid_out drops", valid_out, 1'b0);
        check_vec("R9 result held", result, held);

        // R9: back-to-back captures
        @(negedge clk);
        a = rnd256(); b = rnd256();
        op = 4'b0101; src_a = a; src_b = b; valid_in = 1'b1;
        @(negedge clk);
        check_vec("R9 first of pair", result, model_vec(4'b0101, a, b));
        a = rnd256();
        op = 4'b1001; src_a = a;
        @(negedge clk);
        valid_in = 1'b0;
        check_vec("R9 second of pair", result, model_vec(4'b1001, a, b));
        check_bit("R9 valid_out stays high", valid_out, 1'b1);

        // R10: reset and valid_in in the same cycle
        @(negedge clk);
        rst = 1'b1; valid_in = 1'b1; op = 4'b1000; src_a = {16{16'h0042}}; src_b = '0;
        @(negedge clk);
        rst = 1'b0; valid_in = 1'b0;
        check_vec("R10 reset beats capture", result, '0);
        check_bit("R10 reset clears valid_out", valid_out, 1'b0);

        // Sweep: every op code, mixed operand patterns
        for (int o = 0; o < 16; o++) begin
            for (int n = 0; n < 40; n++) begin
                a = rnd256();
                b = rnd256();
                case (n % 4)
                    1: a = a | {16{16'h8000}} | {8{32'h80000000}};
                    2: a = a & {16{16'h01ff}};
                    3: a = ~(a & {8{32'h0000_ffff}});
                    default: ;
                endcase
                if (n < 16) for (int k = 0; k < 16; k++) b[k*16 +: 4] = 4'(n);
                apply(4'(o), a, b);
                check_vec(tag_of(4'(o)), result, model_vec(4'(o), a, b));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule